// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block picks one of two free-running source clocks and drives it onto a single clock output. Moving from one source to the other never cuts a high phase short and never produces an extra narrow pulse. The source being left finishes its current cycle and is then released. Only after that is the other source requested. The newly chosen source must then count a fixed number of its own rising edges before its gate opens. The only visible effect of a change is a longer low interval on the output.

A single select bit, typically written by a configuration register, chooses the source. The sequencing state machine runs on source 0, and the block raises a busy flag while a change is in progress. Software must keep both source clocks running from the moment it changes the select bit until busy clears. The same applies after reset, because the block brings up source 0 with the same sequence.

Top module: `glitchfree_clk_mux`

## Requirements
- R1: While `rst` is high, `clk_o` is low and `busy_o` is high. After release, source 0 is brought up like a switch: `clk_o` stays low for at least SETTLE_CYCLES (default 5) periods of `clk_src0`, then follows `clk_src0`, and `busy_o` falls.
- R2: `sel_i` = 0 selects `clk_src0` and `sel_i` = 1 selects `clk_src1`. While `busy_o` is low, `clk_o` carries pulses of the selected source only.
- R3: Every high pulse on `clk_o` is one complete high phase of one source. The old source's current cycle always finishes, and no shortened pulse appears.
- R4: Between the last pulse of the old source and the first pulse of the new one, `clk_o` stays low for at least SETTLE_CYCLES periods of the new source.
- R5: Break before make: the two source gates are never open together. A switch releases the old source before it requests the new one, so output pulses of the two sources never interleave.
- R6: `busy_o` rises a few `clk_src0` cycles after `sel_i` differs from the active channel. It falls only once the new source already drives `clk_o`. While `busy_o` is low, the open gate is the requested one.
- R7: Writing the channel that is already active leaves `busy_o` low and the output unchanged.
- R8: A change of `sel_i` during a switch is held. The current switch completes, `busy_o` drops for one `clk_src0` cycle, and a second switch then carries out the held change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src0 | input | 1 | Source clock 0; also clocks the sequencing logic |
| clk_src1 | input | 1 | Source clock 1, unrelated to source 0 |
| rst | input | 1 | Active-high reset, synchronous to `clk_src0` |
| sel_i | input | 1 | Requested source (0 or 1), may change at any time |
| clk_o | output | 1 | Selected clock |
| busy_o | output | 1 | High while a source change is in progress |

## Verification
Suppose the sequencing state went wrong, for example a stale acknowledge or a request raised too early. The first sign would be a high pulse on `clk_o` whose width matches neither source, or a pulse from one source appearing between pulses of the other, within one period of the source being released. A settle counter that is short or skipped would show up as a low gap narrower than five periods of the new source, visible at the first output rise after the switch. Busy logic that is out of step would show busy low while the output still carries the old source or is still low, within a few `clk_src0` cycles of the change.

// File: rtl/gfcm_pkg.sv
`timescale 1ns/1ps
package gfcm_pkg;
  // Sequencer states, clocked by source 0.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // one source live, select matches
    ST_DROP  = 2'd1,  // old source released, waiting for its gate to close
    ST_RAISE = 2'd2   // new source requested, waiting for its gate to open
  } sw_state_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/gfcm_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a single level signal.
module gfcm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gfcm_src_gate.sv
`timescale 1ns/1ps
// Per-source gate: synchronizes the request, waits SETTLE rising edges,
// then opens the gate on a falling edge so it only changes while low.
module gfcm_src_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE      = 5
) (
  input  logic clk_src,
  input  logic rst_a,     // reset from the control domain
  input  logic req,       // request from the control domain
  output logic en_q,      // gate state, changes on falling edge only
  output logic gclk
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);

  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   loc_rst;
  logic                   req_s;
  logic [CNT_W-1:0]       cnt;
  logic                   live;

  // Bring the reset into this source's domain.
  always_ff @(posedge clk_src) begin
    rst_chain <= {rst_chain[SYNC_STAGES-2:0], rst_a};
  end
  assign loc_rst = rst_chain[SYNC_STAGES-1];

  gfcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk (clk_src),
    .rst (loc_rst),
    .d   (req),
    .q   (req_s)
  );

  // Settle counter: counts own rising edges while requested.
  always_ff @(posedge clk_src) begin
    if (loc_rst)              cnt <= '0;
    else if (!req_s)          cnt <= '0;
    else if (cnt != SETTLE_C) cnt <= cnt + 1'b1;
  end

  assign live = req_s && (cnt == SETTLE_C);

  // Gate register on the falling edge: opening or closing only while low.
  always_ff @(negedge clk_src) begin
    if (loc_rst) en_q <= 1'b0;
    else         en_q <= live;
  end

  assign gclk = clk_src & en_q;
endmodule

// File: rtl/gfcm_ctrl.sv
`timescale 1ns/1ps
// Switch sequencer, clocked by source 0.
module gfcm_ctrl
  import gfcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic [NUM_SRC-1:0] en_vec,   // gate states from source domains
  output logic [NUM_SRC-1:0] req,
  output logic               busy
);
  sw_state_e          state;
  logic               active;
  logic               target;
  logic               sel_s;
  logic [NUM_SRC-1:0] ack;

  gfcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sel_sync (
    .clk (clk),
    .rst (rst),
    .d   (sel),
    .q   (sel_s)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
    gfcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk (clk),
      .rst (rst),
      .d   (en_vec[g]),
      .q   (ack[g])
    );
  end

  // Reset enters RAISE towards source 0, so start-up uses the switch path.
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RAISE;
      active <= 1'b0;
      target <= 1'b0;
      req    <= 2'b01;
      busy   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sel_s != active) begin
            state       <= ST_DROP;
            target      <= ~active;
            req[active] <= 1'b0;
            busy        <= 1'b1;
          end
        end
        ST_DROP: begin
          if (!ack[active]) begin
            state       <= ST_RAISE;
            req[target] <= 1'b1;
          end
        end
        ST_RAISE: begin
          if (ack[target]) begin
            state  <= ST_IDLE;
            active <= target;
            busy   <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/glitchfree_clk_mux.sv
`timescale 1ns/1ps
module glitchfree_clk_mux
  import gfcm_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 5
) (
  input  logic clk_src0,
  input  logic clk_src1,
  input  logic rst,
  input  logic sel_i,
  output logic clk_o,
  output logic busy_o
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] src_req;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_gclk;

  assign src_clk = {clk_src1, clk_src0};

  gfcm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk_src0),
    .rst    (rst),
    .sel    (sel_i),
    .en_vec (src_en),
    .req    (src_req),
    .busy   (busy_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    gfcm_src_gate #(
      .SYNC_STAGES (SYNC_STAGES),
      .SETTLE      (SETTLE_CYCLES)
    ) u_gate (
      .clk_src (src_clk[g]),
      .rst_a   (rst),
      .req     (src_req[g]),
      .en_q    (src_en[g]),
      .gclk    (src_gclk[g])
    );
  end

  assign clk_o = |src_gclk;
endmodule

// File: rtl/glitchfree_clk_mux_chk.sv
`timescale 1ns/1ps
module glitchfree_clk_mux_chk (
  input logic       clk_ctl,
  input logic       rst,
  input logic       busy,
  input logic [1:0] en_vec,
  input logic [1:0] req_vec
);
  // R5: both gates never open together
  p_gate_excl_r5: assert property (@(posedge clk_ctl) disable iff (rst)
    !(en_vec[0] && en_vec[1]));

  // R5: a switch starts by withdrawing every request
  p_break_first_r5: assert property (@(posedge clk_ctl) disable iff (rst)
    $rose(busy) |-> (req_vec == 2'b00));

  // R6: when idle the open gate is the requested one
  p_idle_match_r6: assert property (@(posedge clk_ctl) disable iff (rst)
    !busy |-> (en_vec == req_vec));

  // R6: busy cannot clear while the requested gate is still closed
  p_hold_busy_r6: assert property (@(posedge clk_ctl) disable iff (rst)
    (busy && ((en_vec & req_vec) == 2'b00)) |=> busy);
endmodule

bind glitchfree_clk_mux glitchfree_clk_mux_chk u_chk (
  .clk_ctl (clk_src0),
  .rst     (rst),
  .busy    (busy_o),
  .en_vec  (src_en),
  .req_vec (src_req)
);

// File: tb/glitchfree_clk_mux_test.sv
`timescale 1ns/1ps
module glitchfree_clk_mux_test;
  localparam real T0  = 8.0;
  localparam real T1  = 5.3;
  localparam real HI0 = 4.0;
  localparam real HI1 = 2.65;
  localparam int  SETTLE = 5;

  logic clk0 = 1'b0;
  logic clk1 = 1'b0;
  logic rst  = 1'b1;
  logic sel_i = 1'b0;
  logic clk_o, busy_o;

  int checks = 0, errors = 0, wd = 0;
  int n0 = 0, n1 = 0, nbad = 0, nchg = 0, last_cls = -1;
  int busy_rises = 0, busy_falls = 0;
  bit mon_on = 0, seen_rise = 0;
  real t_rise = 0.0, t_fall = 0.0, max_gap = 0.0, t_first = 0.0;

  always #4.0  clk0 = ~clk0;
  always #2.65 clk1 = ~clk1;

  glitchfree_clk_mux uut (
    .clk_src0 (clk0), .clk_src1 (clk1), .rst (rst),
    .sel_i (sel_i), .clk_o (clk_o), .busy_o (busy_o)
  );

  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  // Output pulse monitor
  always @(posedge clk_o) begin
    if (mon_on) begin
      if ($realtime - t_fall > max_gap) max_gap = $realtime - t_fall;
      if (!seen_rise) begin seen_rise = 1; t_first = $realtime; end
    end
    t_rise = $realtime;
  end

  always @(negedge clk_o) begin
    int cls;
    real w;
    t_fall = $realtime;
    if (mon_on) begin
      w = t_fall - t_rise;
      if (rabs(w - HI0) < 0.05)      cls = 0;
      else if (rabs(w - HI1) < 0.05) cls = 1;
      else                           cls = 2;
      if (cls == 0) n0++;
      else if (cls == 1) n1++;
      else nbad++;
      if (last_cls >= 0 && cls != last_cls) nchg++;
      last_cls = cls;
    end
  end

  always @(posedge busy_o) if (mon_on) busy_rises++;
  always @(negedge busy_o) if (mon_on) busy_falls++;

  always @(posedge clk0) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0f exp %0f", req, act, exp);
    end
  endtask

  task automatic wait_busy(input logic lvl, input int maxc, output bit ok);
    ok = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk0);
      if (busy_o === lvl) begin ok = 1; break; end
    end
  endtask

  // R1: reset state and start-up on source 0
  task automatic t_reset();
    bit ok;
    real t_rel;
    rst = 1; sel_i = 0;
    repeat (12) @(posedge clk0);
    @(negedge clk0);
    chk(clk_o === 1'b0, "R1 clk_o low in reset", real'(clk_o), 0.0);
    chk(busy_o === 1'b1, "R1 busy high in reset", real'(busy_o), 1.0);
    t_fall = $realtime;
    mon_on = 1;
    @(posedge clk0); #1;
    rst = 0;
    t_rel = $realtime;
    wait_busy(0, 80, ok);
    chk(ok, "R1 busy clears after start-up", real'(busy_o), 0.0);
    chk(seen_rise && (t_first - t_rel >= SETTLE * T0),
        "R1 start-up low time", t_first - t_rel, SETTLE * T0);
  endtask

  // R2: steady state carries only the selected source
  task automatic t_steady(input bit src);
    int s0, s1;
    s0 = n0; s1 = n1;
    repeat (20) @(negedge clk0);
    if (src == 0)
      chk((n1 == s1) && (n0 - s0 >= 15), "R2 only source 0 pulses", real'(n1 - s1), 0.0);
    else
      chk((n0 == s0) && (n1 - s1 >= 25), "R2 only source 1 pulses", real'(n0 - s0), 0.0);
    chk(busy_o === 1'b0, "R2 busy low in steady state", real'(busy_o), 0.0);
  endtask

  // R3..R6: one switch to new_sel
  task automatic t_switch(input bit new_sel);
    bit ok;
    int s0, s1, sc, sb, live_new;
    real tnew;
    tnew = new_sel ? T1 : T0;
    s0 = n0; s1 = n1; sc = nchg; sb = nbad;
    max_gap = 0.0;
    @(posedge clk0); #1;
    sel_i = new_sel;
    wait_busy(1, 20, ok);
    chk(ok, "R6 busy rises after select change", real'(busy_o), 1.0);
    wait_busy(0, 300, ok);
    chk(ok, "R6 busy clears", real'(busy_o), 0.0);
    live_new = new_sel ? (n1 - s1) : (n0 - s0);
    chk(live_new >= 1, "R6 new source live when busy clears", real'(live_new), 1.0);
    repeat (20) @(negedge clk0);
    chk(max_gap >= SETTLE * tnew, "R4 low gap", max_gap, SETTLE * tnew);
    chk(nchg - sc == 1, "R5 old then new pulses, not interleaved", real'(nchg - sc), 1.0);
    chk(nbad == sb, "R3 no shortened pulse during switch", real'(nbad - sb), 0.0);
  endtask

  // R7: writing the active channel changes nothing
  task automatic t_same(input bit cur);
    int sr, s0, s1;
    sr = busy_rises; s0 = n0; s1 = n1;
    @(posedge clk0); #1;
    sel_i = cur;
    repeat (40) @(negedge clk0);
    chk(busy_rises == sr && busy_o === 1'b0, "R7 busy stays low", real'(busy_rises - sr), 0.0);
    if (cur == 0) chk(n1 == s1, "R7 output unchanged", real'(n1 - s1), 0.0);
    else          chk(n0 == s0, "R7 output unchanged", real'(n0 - s0), 0.0);
  endtask

  // R8: change during busy is held and applied afterwards (0 -> 1 -> 0)
  task automatic t_queued();
    bit ok;
    int sf, s1, sc;
    sf = busy_falls; s1 = n1; sc = nchg;
    @(posedge clk0); #1;
    sel_i = 1;
    wait_busy(1, 20, ok);
    #1 sel_i = 0;
    ok = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk0);
      if (busy_falls - sf >= 2 && busy_o === 1'b0) begin ok = 1; break; end
    end
    chk(ok, "R8 two switches complete", real'(busy_falls - sf), 2.0);
    chk(n1 - s1 >= 1, "R8 held request ran first switch", real'(n1 - s1), 1.0);
    chk(nchg - sc == 2, "R8 back on source 0 after second switch", real'(nchg - sc), 2.0);
  endtask

  initial begin
    t_reset();
    t_steady(0);
    t_same(0);
    t_switch(1);
    t_steady(1);
    t_same(1);
    t_switch(0);
    t_steady(0);
    t_queued();
    t_steady(0);
    chk(nbad == 0, "R3 every pulse is a full source high phase", real'(nbad), 0.0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule